// File: doc/BRIEF.md
# Fringe profile detrend and correlator

This block takes one interference fringe profile at a time, a run of a fixed number of signed pixel intensities sent one per clock, each profile tagged with an identifier. The intensity along a profile is a cosine fringe with a known spatial frequency, sitting on a linear tilt. The block fits that tilt by least squares and subtracts it. No divider is used: the slope and offset come from multiplying by reciprocals fixed at elaboration and then shifting right. It then estimates the fringe amplitude from the extremes of the corrected samples. It also correlates the corrected samples against stored sine and cosine samples of the profile's frequency.

The corrected values can only be formed once the tilt is known, so the whole profile is held in a buffer. The input handshake stays low from the last pixel of a profile until that profile's results leave. The sine and cosine tables are loaded through a write port. They hold several independent sets, called slots, and the low bits of a profile's identifier select the slot it uses. A downstream phase search takes the two sums and the amplitude.

Top module: `fringe_detrend_corr`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: A pixel is taken when `in_valid` and `in_ready` are both 1. After the NPIX-th pixel taken, `in_ready` stays 0 until that profile's result has been presented. Pixels offered while `in_ready` is 0 do not change any result. Pixel k of a profile (k counted from 0) has position x = k.
- R3: With Sy = ΣI(x), Sxy = Σx·I(x), Sx = NPIX(NPIX−1)/2 and Sxx = Σx², the slope is a = ((NPIX·Sxy − Sx·Sy)·Ks) >>> 24. Here Ks = floor((2^(24+FRAC) + D/2) / D) and D = NPIX·Sxx − Sx². The slope carries FRAC fraction bits.
- R4: The offset is b = (((Sy <<< FRAC) − a·Sx)·Km) >>> 24 with Km = floor((2^24 + NPIX/2) / NPIX). Each corrected sample is c(x) = ((I(x) <<< FRAC) − a·x − b) >>> FRAC. All shifts are arithmetic.
- R5: `out_amp` equals (max c − min c) >>> 1 over the profile and is never negative.
- R6: `out_sin` = Σ c(x)·S[s][x] and `out_cos` = Σ c(x)·C[s][x]. S and C are the stored table entries and s = `in_id` mod NSLOT of the profile.
- R7: Each result is presented with `out_valid` high for exactly one cycle. `out_id` equals the identifier that came with the profile's first pixel.
- R8: When `tbl_we` is 1, `tbl_data` is written at index `tbl_idx` of slot `tbl_slot`. `tbl_sel` = 0 picks the sine table and 1 picks the cosine table. A write with `tbl_idx` ≥ NPIX is discarded. Written entries are used by later profiles.
- R9: `in_ready` is 1 in the cycle after the one in which `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block can take a pixel |
| in_pix | input | PIX_W | Signed pixel intensity |
| in_id | input | ID_W | Profile identifier, sampled with the first pixel |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | 0 sine table, 1 cosine table |
| tbl_slot | input | log2(NSLOT) | Table slot written |
| tbl_idx | input | log2(NPIX) rounded up | Sample index written |
| tbl_data | input | TBL_W | Signed table value |
| out_valid | output | 1 | Result strobe |
| out_id | output | ID_W | Identifier of the finished profile |
| out_amp | output | CORR_W | Signed amplitude estimate |
| out_sin | output | SUM_W | Signed sine correlation |
| out_cos | output | SUM_W | Signed cosine correlation |

## Verification
The assertions assume the source obeys the handshake and sends no more than NPIX accepted pixels per profile. They also assume the corrected samples fit in CORR_W bits. The stimulus keeps pixels inside ±2048 in every pattern, flat, ramped, fringed, alternating and random, so the residuals after detrending stay well inside 18 bits. Tables are written only while no profile is being processed. On some profiles the bench holds `in_valid` high with junk data during the busy time, so that back-pressure is exercised without breaking the protocol the checker relies on.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int RECIP_SHIFT = 24;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_COV,
        ENG_SLOPE,
        ENG_OFFSET,
        ENG_SCAN,
        ENG_EMIT
    } eng_state_e;

    function automatic longint pos_sum(input int n);
        longint ln;
        ln = longint'(n);
        return ln * (ln - 1) / 2;
    endfunction

    function automatic longint pos_sq_sum(input int n);
        longint ln;
        ln = longint'(n);
        return (ln - 1) * ln * (2 * ln - 1) / 6;
    endfunction

    function automatic longint slope_recip(input int n, input int frac);
        longint d;
        d = longint'(n) * pos_sq_sum(n) - pos_sum(n) * pos_sum(n);
        return ((longint'(1) <<< (RECIP_SHIFT + frac)) + d / 2) / d;
    endfunction

    function automatic longint mean_recip(input int n);
        return ((longint'(1) <<< RECIP_SHIFT) + longint'(n / 2)) / longint'(n);
    endfunction

endpackage

// File: rtl/fdc_trig_tables.sv
module fdc_trig_tables #(
    parameter int NPIX  = 20,
    parameter int NSLOT = 4,
    parameter int TBL_W = 16
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic                           wr_sel,
    input  logic [$clog2(NSLOT)-1:0]       wr_slot,
    input  logic [$clog2(NPIX)-1:0]        wr_idx,
    input  logic signed [TBL_W-1:0]        wr_data,
    input  logic [$clog2(NSLOT)-1:0]       rd_slot,
    input  logic [$clog2(NPIX)-1:0]        rd_idx,
    output logic signed [TBL_W-1:0]        rd_sin,
    output logic signed [TBL_W-1:0]        rd_cos
);
    localparam int DEPTH  = NSLOT * NPIX;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0]       wr_addr;
    logic [ADDR_W-1:0]       rd_addr;
    logic                    wr_ok;
    logic signed [TBL_W-1:0] rd_val [2];

    always_comb begin
        wr_ok   = wr_en && (int'(wr_idx) < NPIX);
        wr_addr = ADDR_W'(int'(wr_slot) * NPIX + int'(wr_idx));
        rd_addr = ADDR_W'(int'(rd_slot) * NPIX + int'(rd_idx));
    end

    for (genvar g = 0; g < 2; g++) begin : g_table
        logic signed [TBL_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_ok && (wr_sel == 1'(g))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_val[g] = mem[rd_addr];
    end

    assign rd_sin = rd_val[0];
    assign rd_cos = rd_val[1];

endmodule

// File: rtl/fdc_capture.sv
module fdc_capture #(
    parameter int NPIX  = 20,
    parameter int PIX_W = 12,
    parameter int ID_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic signed [PIX_W-1:0]     in_pix,
    input  logic [ID_W-1:0]             in_id,
    input  logic                        release_buf,
    input  logic [$clog2(NPIX)-1:0]     rd_idx,
    output logic                        buf_full,
    output logic signed [63:0]          sum_i,
    output logic signed [63:0]          sum_xi,
    output logic [ID_W-1:0]             prof_id,
    output logic signed [PIX_W-1:0]     rd_pix
);
    localparam int IDX_W = $clog2(NPIX);

    typedef struct packed {
        logic                           full;
        logic [IDX_W-1:0]               cnt;
        logic [ID_W-1:0]                id;
        logic signed [63:0]             sy;
        logic signed [63:0]             sxy;
        logic [NPIX-1:0][PIX_W-1:0]     pixels;
    } cap_t;

    cap_t cap_d, cap_q;
    logic take;

    always_comb begin
        cap_d = cap_q;
        take  = in_valid && !cap_q.full;
        if (take) begin
            cap_d.pixels[cap_q.cnt] = in_pix;
            cap_d.sy  = cap_q.sy + 64'(in_pix);
            cap_d.sxy = cap_q.sxy + 64'(signed'({1'b0, cap_q.cnt})) * 64'(in_pix);
            if (cap_q.cnt == '0) begin
                cap_d.id = in_id;
            end
            if (int'(cap_q.cnt) == NPIX - 1) begin
                cap_d.full = 1'b1;
                cap_d.cnt  = '0;
            end else begin
                cap_d.cnt = cap_q.cnt + 1'b1;
            end
        end
        if (cap_q.full && release_buf) begin
            cap_d.full = 1'b0;
            cap_d.cnt  = '0;
            cap_d.sy   = '0;
            cap_d.sxy  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign in_ready = !cap_q.full;
    assign buf_full = cap_q.full;
    assign sum_i    = cap_q.sy;
    assign sum_xi   = cap_q.sxy;
    assign prof_id  = cap_q.id;
    assign rd_pix   = signed'(cap_q.pixels[rd_idx]);

endmodule

// File: rtl/fdc_engine.sv
module fdc_engine
    import fdc_pkg::*;
#(
    parameter int NPIX   = 20,
    parameter int PIX_W  = 12,
    parameter int TBL_W  = 16,
    parameter int FRAC   = 8,
    parameter int CORR_W = 18,
    parameter int SUM_W  = 40
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        buf_full,
    input  logic signed [63:0]          sum_i,
    input  logic signed [63:0]          sum_xi,
    input  logic signed [PIX_W-1:0]     rd_pix,
    input  logic signed [TBL_W-1:0]     tbl_sin,
    input  logic signed [TBL_W-1:0]     tbl_cos,
    output logic [$clog2(NPIX)-1:0]     rd_idx,
    output logic                        release_buf,
    output logic                        res_valid,
    output logic signed [CORR_W-1:0]    res_amp,
    output logic signed [SUM_W-1:0]     res_sin,
    output logic signed [SUM_W-1:0]     res_cos
);
    localparam int IDX_W = $clog2(NPIX);
    localparam logic signed [63:0] SX     = 64'(pos_sum(NPIX));
    localparam logic signed [63:0] NPIX_S = 64'(NPIX);
    localparam logic signed [63:0] K_SLP  = 64'(slope_recip(NPIX, FRAC));
    localparam logic signed [63:0] K_MEAN = 64'(mean_recip(NPIX));
    localparam logic signed [CORR_W-1:0] C_MAX = {1'b0, {(CORR_W-1){1'b1}}};
    localparam logic signed [CORR_W-1:0] C_MIN = {1'b1, {(CORR_W-1){1'b0}}};

    typedef struct packed {
        eng_state_e                 st;
        logic [IDX_W-1:0]           idx;
        logic signed [63:0]         cov;
        logic signed [63:0]         slope;
        logic signed [63:0]         offs;
        logic signed [CORR_W-1:0]   vmax;
        logic signed [CORR_W-1:0]   vmin;
        logic signed [63:0]         acc_s;
        logic signed [63:0]         acc_c;
    } eng_t;

    eng_t eng_d, eng_q;
    logic signed [63:0]       corr_w;
    logic signed [CORR_W-1:0] corr_t;
    logic signed [63:0]       span;

    always_comb begin
        eng_d  = eng_q;
        corr_w = ((64'(rd_pix) <<< FRAC)
                  - eng_q.slope * 64'(signed'({1'b0, eng_q.idx}))
                  - eng_q.offs) >>> FRAC;
        corr_t = CORR_W'(corr_w);
        span   = (64'(eng_q.vmax) - 64'(eng_q.vmin)) >>> 1;
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (buf_full) begin
                    eng_d.st = ENG_COV;
                end
            end
            ENG_COV: begin
                eng_d.cov = NPIX_S * sum_xi - SX * sum_i;
                eng_d.st  = ENG_SLOPE;
            end
            ENG_SLOPE: begin
                eng_d.slope = (eng_q.cov * K_SLP) >>> RECIP_SHIFT;
                eng_d.st    = ENG_OFFSET;
            end
            ENG_OFFSET: begin
                eng_d.offs  = (((sum_i <<< FRAC) - eng_q.slope * SX) * K_MEAN) >>> RECIP_SHIFT;
                eng_d.idx   = '0;
                eng_d.vmax  = C_MIN;
                eng_d.vmin  = C_MAX;
                eng_d.acc_s = '0;
                eng_d.acc_c = '0;
                eng_d.st    = ENG_SCAN;
            end
            ENG_SCAN: begin
                if (corr_t > eng_q.vmax) begin
                    eng_d.vmax = corr_t;
                end
                if (corr_t < eng_q.vmin) begin
                    eng_d.vmin = corr_t;
                end
                eng_d.acc_s = eng_q.acc_s + 64'(corr_t) * 64'(tbl_sin);
                eng_d.acc_c = eng_q.acc_c + 64'(corr_t) * 64'(tbl_cos);
                if (int'(eng_q.idx) == NPIX - 1) begin
                    eng_d.st = ENG_EMIT;
                end else begin
                    eng_d.idx = eng_q.idx + 1'b1;
                end
            end
            ENG_EMIT: begin
                eng_d.st = ENG_IDLE;
            end
            default: begin
                eng_d.st = ENG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ENG_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rd_idx      = eng_q.idx;
    assign release_buf = (eng_q.st == ENG_EMIT);
    assign res_valid   = (eng_q.st == ENG_EMIT);
    assign res_amp     = CORR_W'(span);
    assign res_sin     = SUM_W'(eng_q.acc_s);
    assign res_cos     = SUM_W'(eng_q.acc_c);

endmodule

// File: rtl/fringe_detrend_corr.sv
module fringe_detrend_corr #(
    parameter int NPIX   = 20,
    parameter int PIX_W  = 12,
    parameter int ID_W   = 8,
    parameter int NSLOT  = 4,
    parameter int TBL_W  = 16,
    parameter int FRAC   = 8,
    parameter int CORR_W = 18,
    parameter int SUM_W  = 40
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic signed [PIX_W-1:0]         in_pix,
    input  logic [ID_W-1:0]                 in_id,
    input  logic                            tbl_we,
    input  logic                            tbl_sel,
    input  logic [$clog2(NSLOT)-1:0]        tbl_slot,
    input  logic [$clog2(NPIX)-1:0]         tbl_idx,
    input  logic signed [TBL_W-1:0]         tbl_data,
    output logic                            out_valid,
    output logic [ID_W-1:0]                 out_id,
    output logic signed [CORR_W-1:0]        out_amp,
    output logic signed [SUM_W-1:0]         out_sin,
    output logic signed [SUM_W-1:0]         out_cos
);
    localparam int IDX_W  = $clog2(NPIX);
    localparam int SLOT_W = $clog2(NSLOT);

    logic                    buf_full;
    logic                    release_buf;
    logic signed [63:0]      sum_i;
    logic signed [63:0]      sum_xi;
    logic [ID_W-1:0]         prof_id;
    logic signed [PIX_W-1:0] rd_pix;
    logic [IDX_W-1:0]        rd_idx;
    logic signed [TBL_W-1:0] tbl_sin;
    logic signed [TBL_W-1:0] tbl_cos;

    fdc_capture #(.NPIX(NPIX), .PIX_W(PIX_W), .ID_W(ID_W)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_id(in_id),
        .release_buf(release_buf), .rd_idx(rd_idx),
        .buf_full(buf_full), .sum_i(sum_i), .sum_xi(sum_xi),
        .prof_id(prof_id), .rd_pix(rd_pix)
    );

    fdc_trig_tables #(.NPIX(NPIX), .NSLOT(NSLOT), .TBL_W(TBL_W)) tbl_i (
        .clk(clk),
        .wr_en(tbl_we), .wr_sel(tbl_sel), .wr_slot(tbl_slot),
        .wr_idx(tbl_idx), .wr_data(tbl_data),
        .rd_slot(prof_id[SLOT_W-1:0]), .rd_idx(rd_idx),
        .rd_sin(tbl_sin), .rd_cos(tbl_cos)
    );

    fdc_engine #(
        .NPIX(NPIX), .PIX_W(PIX_W), .TBL_W(TBL_W), .FRAC(FRAC),
        .CORR_W(CORR_W), .SUM_W(SUM_W)
    ) eng_i (
        .clk(clk), .rst_n(rst_n),
        .buf_full(buf_full), .sum_i(sum_i), .sum_xi(sum_xi),
        .rd_pix(rd_pix), .tbl_sin(tbl_sin), .tbl_cos(tbl_cos),
        .rd_idx(rd_idx), .release_buf(release_buf),
        .res_valid(out_valid), .res_amp(out_amp),
        .res_sin(out_sin), .res_cos(out_cos)
    );

    assign out_id = prof_id;

endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
    parameter int NPIX   = 20,
    parameter int CORR_W = 18
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic signed [CORR_W-1:0] out_amp
);
    int taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken <= 0;
        end else if (out_valid) begin
            taken <= 0;
        end else if (in_valid && in_ready) begin
            taken <= taken + 1;
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R7

    AST_READY_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> in_ready); // R9

    AST_HELD_DURING_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R2

    AST_FULL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (taken == NPIX) |-> !in_ready); // R2

    AST_RESULT_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (taken == NPIX)); // R2

    AST_AMP_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_amp[CORR_W-1]); // R5

endmodule

bind fringe_detrend_corr fdc_checker #(.NPIX(NPIX), .CORR_W(CORR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_amp(out_amp)
);

// File: tb/fringe_detrend_corr_tb.sv
module fringe_detrend_corr_tb_top;
    localparam int NPIX   = 20;
    localparam int PIX_W  = 12;
    localparam int ID_W   = 8;
    localparam int NSLOT  = 4;
    localparam int TBL_W  = 16;
    localparam int FRAC   = 8;
    localparam int CORR_W = 18;
    localparam int SUM_W  = 40;
    localparam real PI = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [PIX_W-1:0] in_pix = '0;
    logic [ID_W-1:0] in_id = '0;
    logic tbl_we = 1'b0;
    logic tbl_sel = 1'b0;
    logic [1:0] tbl_slot = '0;
    logic [4:0] tbl_idx = '0;
    logic signed [TBL_W-1:0] tbl_data = '0;
    logic out_valid;
    logic [ID_W-1:0] out_id;
    logic signed [CORR_W-1:0] out_amp;
    logic signed [SUM_W-1:0] out_sin;
    logic signed [SUM_W-1:0] out_cos;

    int checks = 0;
    int fails = 0;
    longint pix_ref [NPIX];
    longint sin_ref [NSLOT][NPIX];
    longint cos_ref [NSLOT][NPIX];

    always #2.5 clk = ~clk;

    fringe_detrend_corr #(
        .NPIX(NPIX), .PIX_W(PIX_W), .ID_W(ID_W), .NSLOT(NSLOT), .TBL_W(TBL_W),
        .FRAC(FRAC), .CORR_W(CORR_W), .SUM_W(SUM_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_id(in_id), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_slot(tbl_slot), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .out_valid(out_valid), .out_id(out_id), .out_amp(out_amp),
        .out_sin(out_sin), .out_cos(out_cos)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int n = 0; n < 100000; n++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic wr_tbl(input bit sel, input int slot, input int idx, input longint val);
        @(negedge clk);
        tbl_we = 1'b1;
        tbl_sel = sel;
        tbl_slot = 2'(slot);
        tbl_idx = 5'(idx);
        tbl_data = TBL_W'(val);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // reference per R3, R4, R5, R6
    task automatic model(input int id, output longint amp, output longint s, output longint c);
        longint n = NPIX;
        longint sx = 0, sxx = 0, sy = 0, sxy = 0, d, ks, km, a, b, cv, mx, mn;
        int slot = id % NSLOT;
        for (int i = 0; i < NPIX; i++) begin
            sx += i;
            sxx += i * i;
            sy += pix_ref[i];
            sxy += i * pix_ref[i];
        end
        d  = n * sxx - sx * sx;
        ks = ((longint'(1) <<< (24 + FRAC)) + d / 2) / d;
        km = ((longint'(1) <<< 24) + n / 2) / n;
        a  = ((n * sxy - sx * sy) * ks) >>> 24;
        b  = (((sy <<< FRAC) - a * sx) * km) >>> 24;
        mx = -(longint'(1) <<< 40);
        mn = (longint'(1) <<< 40);
        s = 0;
        c = 0;
        for (int i = 0; i < NPIX; i++) begin
            cv = ((pix_ref[i] <<< FRAC) - a * i - b) >>> FRAC;
            if (cv > mx) mx = cv;
            if (cv < mn) mn = cv;
            s += cv * sin_ref[slot][i];
            c += cv * cos_ref[slot][i];
        end
        amp = (mx - mn) >>> 1;
    endtask

    task automatic run_profile(input int id, input bit junk);
        longint e_amp, e_s, e_c;
        int wait_n = 0;
        for (int k = 0; k < NPIX; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix = PIX_W'(pix_ref[k]);
            in_id = ID_W'(id);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = junk;
        in_pix = 12'sd1234;
        in_id = 8'hEE;
        chk("R2 ready low while profile held", longint'(in_ready), 0);
        while (!out_valid && wait_n < 500) begin
            @(negedge clk);
            wait_n++;
        end
        in_valid = 1'b0;
        model(id, e_amp, e_s, e_c);
        chk("R7 result strobe seen", longint'(out_valid), 1);
        chk("R7 identifier", longint'(out_id), longint'(ID_W'(id)));
        chk("R5 amplitude", longint'(out_amp), e_amp);
        chk("R3/R4/R6 sine sum", longint'(out_sin), e_s);
        chk("R3/R4/R6 cosine sum", longint'(out_cos), e_c);
        @(negedge clk);
        chk("R7 strobe single cycle", longint'(out_valid), 0);
        chk("R9 ready after result", longint'(in_ready), 1);
    endtask

    task automatic fill_pattern(input int kind);
        for (int i = 0; i < NPIX; i++) begin
            case (kind)
                0: pix_ref[i] = 0;
                1: pix_ref[i] = 37 * i - 350;
                2: pix_ref[i] = $rtoi($floor(800.0 * $cos(2.0 * PI * 0.23 * i + 0.7) + 15.0 * i - 120.0 + 0.5));
                3: pix_ref[i] = (i % 2 == 0) ? 2047 : -2048;
                4: pix_ref[i] = longint'($urandom_range(0, 4000)) - 2000;
                default: pix_ref[i] = $rtoi($floor(1000.0 * $sin(2.0 * PI * 0.17 * i) - 20.0 * i + 0.5));
            endcase
        end
    endtask

    initial begin
        #1;
        chk("R1 reset out_valid", longint'(out_valid), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", longint'(in_ready), 1);
        chk("R1 no strobe after reset", longint'(out_valid), 0);

        // R8 table load
        for (int s = 0; s < NSLOT; s++) begin
            for (int i = 0; i < NPIX; i++) begin
                sin_ref[s][i] = $rtoi($floor(16000.0 * $sin(2.0 * PI * (s + 2) / 17.0 * i) + 0.5));
                cos_ref[s][i] = $rtoi($floor(16000.0 * $cos(2.0 * PI * (s + 2) / 17.0 * i) + 0.5));
                wr_tbl(1'b0, s, i, sin_ref[s][i]);
                wr_tbl(1'b1, s, i, cos_ref[s][i]);
            end
        end

        for (int p = 0; p < 18; p++) begin
            fill_pattern(p % 6);
            run_profile(p * 7 + 1, p % 2 == 1);
        end

        // R8 rewrite slot 1 and check a discarded out-of-range write
        for (int i = 0; i < NPIX; i++) begin
            cos_ref[1][i] = 1000;
            wr_tbl(1'b1, 1, i, 1000);
        end
        sin_ref[1][5] = -777;
        wr_tbl(1'b0, 1, 5, -777);
        wr_tbl(1'b0, 0, 25, 9999);
        fill_pattern(4);
        run_profile(5, 1'b0);
        fill_pattern(2);
        run_profile(9, 1'b1);

        summary();
    end

endmodule